// File: doc/BRIEF.md
# Quad-Lane SPI Master Word Shifter

This block is the data engine of an SPI master that moves one word per transaction over four data lanes. Each serial clock carries one nibble. A strobe on `start` latches the configuration and the parallel word, and a transfer begins. Chip select stays low for the whole word. In transmit mode the engine drives all four pins from the word, with the most significant nibble first. In receive mode it releases all four pins, samples them on every rising serial clock edge, and returns the assembled word right-justified.

The four lanes reuse the two MOSI pins and the two MISO pins of an ordinary SPI port, in interleaved order. Even lane bits go to the MOSI pins and odd lane bits go to the MISO pins. The engine refuses a start that asks for an illegal mix of modes and reports it with a one-cycle error pulse. The serial clock runs at a fixed ratio of the system clock: each half period lasts `HALF_DIV` system cycles.

Top module: `qspi_word_engine`

## Requirements
- R1: A `start` while idle, with quad enabled and dual, three-wire and byte-swap all clear, makes `busy` high and `cs_n` low from the next cycle until the transfer ends.
- R2: The length code `cfg_len` (0, 1, 2, 3) selects 8, 16, 24 or 32 bits, which gives exactly 2, 4, 6 or 8 rising `sclk` edges.
- R3: While transmitting, pin index 0 (first MOSI) carries lane bit 0, index 2 (first MISO) lane bit 1, index 1 (second MOSI) lane bit 2, and index 3 (second MISO) lane bit 3. `pin_oe` is 4'hF for the whole transfer.
- R4: Transmit nibbles leave most significant first: the k-th rising edge presents bits [4(N-1-k)+3 : 4(N-1-k)] of the word, where N is the nibble count. Pin values change only while `sclk` is low.
- R5: While receiving, `pin_oe` is 0. Lanes are sampled at each rising edge, the first sample lands in the most significant nibble, and `rd_data` holds the word right-justified with the upper bits zero.
- R6: A start with quad and dual both enabled gives a one-cycle `cfg_err` pulse and no transfer.
- R7: A start with quad enabled and either three-wire or byte-swap set gives a one-cycle `cfg_err` pulse and no transfer.
- R8: A start with quad disabled gives a one-cycle `cfg_err` pulse and no transfer.
- R9: `sclk` idles low. `cs_n` is low at every rising `sclk` edge and high again once the transfer ends.
- R10: `done` pulses for exactly one cycle at the end of a transfer, in the same cycle that `busy` falls.
- R11: A `start` that arrives while `busy` is ignored: the running transfer keeps its length and no extra transfer follows.
- R12: `rd_data` changes only at the end of a receive. A transmit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one word transfer |
| cfg_quad_en | input | 1 | Enable quad-lane transfers |
| cfg_dual_en | input | 1 | Dual-lane enable, illegal together with quad |
| cfg_dir_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_len | input | 2 | Word length code: 0/1/2/3 = 8/16/24/32 bits |
| cfg_three_wire | input | 1 | Three-wire slave mode flag, illegal with quad |
| cfg_byte_swap | input | 1 | Byte-reorder flag, illegal with quad |
| wr_data | input | 32 | Word to send, right-justified |
| rd_data | output | 32 | Last received word, right-justified |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | One-cycle rejected-start pulse |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| pin_o | output | 4 | Pin drive values: [0] MOSI0, [1] MOSI1, [2] MISO0, [3] MISO1 |
| pin_oe | output | 4 | Per-pin output enables, same order as `pin_o` |
| pin_i | input | 4 | Pin input values, same order as `pin_o` |

## Verification
The assertions assume that `pin_i` from the external device changes only while `sclk` is low. They also assume that the configuration inputs settle before the cycle that carries `start`, because the engine latches them on acceptance. The bench's responder updates the pins only on chip-select fall and on falling serial clock edges. The bench sets every configuration input at a falling system clock edge before it pulses `start`. Retriggers are sent mid-transfer to exercise R11.

// File: rtl/qspi_pkg.sv
`timescale 1ns/1ps
package qspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_TAIL  = 3'd4
    } qspi_state_t;

    // number of 8-bit groups selected by a length code
    function automatic int unsigned len_bytes(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

endpackage

// File: rtl/qspi_cfg_check.sv
`timescale 1ns/1ps
module qspi_cfg_check (
    input  logic quad_en,
    input  logic dual_en,
    input  logic three_wire,
    input  logic byte_swap,
    output logic reject
);
    logic conflict_d;

    always_comb begin
        conflict_d = dual_en | three_wire | byte_swap;
        reject     = ~quad_en | conflict_d;
    end
endmodule

// File: rtl/qspi_clk_phase.sv
`timescale 1ns/1ps
module qspi_clk_phase #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qspi_lane_map.sv
`timescale 1ns/1ps
module qspi_lane_map #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] nib_tx,
    input  logic [LANES-1:0] pins_in,
    output logic [LANES-1:0] pins_out,
    output logic [LANES-1:0] nib_rx
);
    localparam int HALF = LANES / 2;

    // even lanes land on the MOSI pins (low indices), odd lanes on MISO pins
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int PIN = (l % 2 == 0) ? (l / 2) : (HALF + l / 2);
        assign pins_out[PIN] = nib_tx[l];
        assign nib_rx[l]     = pins_in[PIN];
    end
endmodule

// File: rtl/qspi_word_engine.sv
`timescale 1ns/1ps
module qspi_word_engine
    import qspi_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LANES    = 4,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_quad_en,
    input  logic              cfg_dual_en,
    input  logic              cfg_dir_tx,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_three_wire,
    input  logic              cfg_byte_swap,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic              sclk,
    output logic              cs_n,
    output logic [LANES-1:0]  pin_o,
    output logic [LANES-1:0]  pin_oe,
    input  logic [LANES-1:0]  pin_i
);
    localparam int MAX_NIB = DATA_W / LANES;
    localparam int NCW     = $clog2(MAX_NIB + 1);
    localparam int NIB_PER_BYTE = 8 / LANES;

    typedef struct packed {
        qspi_state_t       st;
        logic              sclk;
        logic              cs_n;
        logic              tx;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rd;
        logic [NCW-1:0]    left;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic             reject;
    logic             tick;
    logic             run;
    logic [LANES-1:0] nib_rx;
    logic [LANES-1:0] mapped_o;

    qspi_cfg_check u_cfg (
        .quad_en    (cfg_quad_en),
        .dual_en    (cfg_dual_en),
        .three_wire (cfg_three_wire),
        .byte_swap  (cfg_byte_swap),
        .reject     (reject)
    );

    assign run = (r_q.st != ST_IDLE);

    qspi_clk_phase #(.HALF_DIV(HALF_DIV)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    qspi_lane_map #(.LANES(LANES)) u_map (
        .nib_tx   (r_q.sh[DATA_W-1 -: LANES]),
        .pins_in  (pin_i),
        .pins_out (mapped_o),
        .nib_rx   (nib_rx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (reject) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st   = ST_SETUP;
                        r_d.cs_n = 1'b0;
                        r_d.tx   = cfg_dir_tx;
                        r_d.sh   = wr_data << (DATA_W - 8 * len_bytes(cfg_len));
                        r_d.rx   = '0;
                        r_d.left = NCW'(NIB_PER_BYTE * len_bytes(cfg_len));
                    end
                end
            end
            ST_SETUP, ST_LOW: begin
                if (tick) begin
                    r_d.st   = ST_HIGH;
                    r_d.sclk = 1'b1;
                    r_d.rx   = {r_q.rx[DATA_W-LANES-1:0], nib_rx};
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    r_d.sclk = 1'b0;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == NCW'(1)) begin
                        r_d.st = ST_TAIL;
                    end else begin
                        r_d.st = ST_LOW;
                        r_d.sh = r_q.sh << LANES;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    r_d.st   = ST_IDLE;
                    r_d.cs_n = 1'b1;
                    r_d.done = 1'b1;
                    if (!r_q.tx) r_d.rd = r_q.rx;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.sclk <= 1'b0;
            r_q.cs_n <= 1'b1;
            r_q.tx   <= 1'b0;
            r_q.sh   <= '0;
            r_q.rx   <= '0;
            r_q.rd   <= '0;
            r_q.left <= '0;
            r_q.done <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.rd;
    assign busy    = run;
    assign done    = r_q.done;
    assign cfg_err = r_q.err;
    assign sclk    = r_q.sclk;
    assign cs_n    = r_q.cs_n;
    assign pin_o   = (run && r_q.tx) ? mapped_o : '0;
    assign pin_oe  = {LANES{run && r_q.tx}};

    // R1: legal start while idle opens a transfer with chip select low
    a_r1_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_quad_en && !cfg_dual_en && !cfg_three_wire && !cfg_byte_swap)
        |=> (busy && !cs_n));

    // R4: lane values are held steady across a rising serial clock edge
    a_r4_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(pin_o));

    // R5: receive never drives any pin
    a_r5_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !pin_oe[0]) |-> (pin_oe == '0));

    // R6: quad plus dual is refused
    a_r6_dual_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_quad_en && cfg_dual_en) |=> (cfg_err && !busy));

    // R7: quad with three-wire or byte reorder is refused
    a_r7_mode_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (cfg_three_wire || cfg_byte_swap)) |=> (cfg_err && !busy));

    // R9: serial clock only toggles high inside an asserted chip select
    a_r9_cs_covers_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R10: done is a single-cycle pulse and coincides with idle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n));

    // R11: remaining nibble count never grows during a transfer
    a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (r_q.left <= $past(r_q.left)));

    // R12: a transmit leaves the read register untouched
    a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.tx) |=> $stable(rd_data));
endmodule

// File: tb/qspi_word_engine_test.sv
`timescale 1ns/1ps
module qspi_word_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_quad_en = 1'b0;
    logic        cfg_dual_en = 1'b0;
    logic        cfg_dir_tx = 1'b0;
    logic [1:0]  cfg_len = 2'd0;
    logic        cfg_three_wire = 1'b0;
    logic        cfg_byte_swap = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, done, cfg_err, sclk, cs_n;
    logic [3:0]  pin_o, pin_oe;
    logic [3:0]  pin_i = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    qspi_word_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_quad_en(cfg_quad_en), .cfg_dual_en(cfg_dual_en),
        .cfg_dir_tx(cfg_dir_tx), .cfg_len(cfg_len),
        .cfg_three_wire(cfg_three_wire), .cfg_byte_swap(cfg_byte_swap),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .done(done),
        .cfg_err(cfg_err), .sclk(sclk), .cs_n(cs_n),
        .pin_o(pin_o), .pin_oe(pin_oe), .pin_i(pin_i)
    );

    // expected pin pattern for a nibble: [0]=b0, [1]=b2, [2]=b1, [3]=b3
    function automatic logic [3:0] pins_of(input logic [3:0] nib);
        return {nib[3], nib[1], nib[2], nib[0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // serial monitor
    int         rise_cnt = 0;
    logic [3:0] cap_o  [0:15];
    logic [3:0] cap_oe [0:15];
    bit         cs_bad = 0;
    bit         chg_bad = 0;

    always @(posedge sclk) begin
        logic [3:0] first;
        #1;
        first = pin_o;
        if (rise_cnt < 16) begin
            cap_o[rise_cnt]  = pin_o;
            cap_oe[rise_cnt] = pin_oe;
        end
        if (cs_n) cs_bad = 1;
        #7;
        if (pin_o !== first) chg_bad = 1;
        rise_cnt++;
    end

    // external device model for receive
    bit          rx_mode = 0;
    logic [31:0] rx_word = '0;
    int          rx_n = 0;
    int          rx_idx = 0;

    always @(negedge cs_n) begin
        if (rx_mode) begin
            rx_idx = rx_n - 1;
            pin_i  = pins_of(rx_word[rx_idx*4 +: 4]);
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && rx_mode) begin
            rx_idx--;
            if (rx_idx >= 0) pin_i = pins_of(rx_word[rx_idx*4 +: 4]);
        end
    end

    task automatic clear_mon();
        rise_cnt = 0;
        cs_bad   = 0;
        chg_bad  = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, {tag, " done seen"}, 32'(done), 32'd1);
    endtask

    task automatic set_cfg(input bit q, input bit d, input bit tx, input logic [1:0] len,
                           input bit tw, input bit bs);
        @(negedge clk);
        cfg_quad_en = q; cfg_dual_en = d; cfg_dir_tx = tx; cfg_len = len;
        cfg_three_wire = tw; cfg_byte_swap = bs;
    endtask

    task automatic t_reset();
        chk(cs_n === 1'b1, "R9 reset cs_n", 32'(cs_n), 32'd1);
        chk(sclk === 1'b0, "R9 reset sclk", 32'(sclk), 32'd0);
        chk(busy === 1'b0 && done === 1'b0, "R10 reset busy/done", {30'd0, busy, done}, 32'd0);
        chk(pin_oe === 4'h0, "R5 reset pin_oe", 32'(pin_oe), 32'd0);
        chk(rd_data === 32'd0, "R12 reset rd_data", rd_data, 32'd0);
    endtask

    task automatic t_write(input logic [1:0] len, input logic [31:0] word);
        int nn = 2 * (int'(len) + 1);
        rx_mode = 0;
        set_cfg(1, 0, 1, len, 0, 0);
        wr_data = word;
        clear_mon();
        pulse_start();
        chk(busy === 1'b1 && cs_n === 1'b0, "R1 write start", {30'd0, busy, cs_n}, 32'h2);
        wait_done("R10 write");
        chk(busy === 1'b0, "R10 busy falls with done", 32'(busy), 32'd0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", 32'(done), 32'd0);
        chk(cs_n === 1'b1 && sclk === 1'b0, "R9 idle after write", {30'd0, cs_n, sclk}, 32'h2);
        #20;
        chk(rise_cnt == nn, "R2 write rise count", 32'(rise_cnt), 32'(nn));
        chk(!cs_bad, "R9 cs low at every rise", 32'(cs_bad), 32'd0);
        chk(!chg_bad, "R4 pins steady while sclk high", 32'(chg_bad), 32'd0);
        for (int k = 0; k < nn; k++) begin
            logic [3:0] exp_nib = word[(nn-1-k)*4 +: 4];
            chk(cap_o[k] === pins_of(exp_nib), "R3 R4 write lane mapping/order",
                32'(cap_o[k]), 32'(pins_of(exp_nib)));
            chk(cap_oe[k] === 4'hF, "R3 write pin_oe", 32'(cap_oe[k]), 32'hF);
        end
    endtask

    task automatic t_read(input logic [1:0] len, input logic [31:0] word);
        int nn = 2 * (int'(len) + 1);
        logic [31:0] mask = (nn == 8) ? 32'hFFFF_FFFF : ((32'd1 << (nn*4)) - 1);
        rx_mode = 1;
        rx_word = word;
        rx_n    = nn;
        set_cfg(1, 0, 0, len, 0, 0);
        clear_mon();
        pulse_start();
        chk(busy === 1'b1, "R1 read start", 32'(busy), 32'd1);
        wait_done("R10 read");
        @(negedge clk);
        rx_mode = 0;
        pin_i = '0;
        #20;
        chk(rise_cnt == nn, "R2 read rise count", 32'(rise_cnt), 32'(nn));
        chk(rd_data === (word & mask), "R5 read word right-justified", rd_data, word & mask);
        for (int k = 0; k < nn; k++)
            chk(cap_oe[k] === 4'h0, "R5 read pin_oe released", 32'(cap_oe[k]), 32'd0);
    endtask

    task automatic t_reject(input bit q, input bit d, input bit tw, input bit bs, input string tag);
        logic [31:0] rd_before = rd_data;
        set_cfg(q, d, 1, 2'd3, tw, bs);
        wr_data = 32'hFFFF_FFFF;
        clear_mon();
        pulse_start();
        chk(cfg_err === 1'b1 && busy === 1'b0, {tag, " error pulse"}, {30'd0, cfg_err, busy}, 32'h2);
        @(negedge clk);
        chk(cfg_err === 1'b0, {tag, " error one cycle"}, 32'(cfg_err), 32'd0);
        repeat (30) @(negedge clk);
        chk(rise_cnt == 0 && cs_n === 1'b1, {tag, " no transfer"}, 32'(rise_cnt), 32'd0);
        chk(rd_data === rd_before, {tag, " rd_data kept"}, rd_data, rd_before);
    endtask

    task automatic t_retrigger();
        int extra = 0;
        rx_mode = 0;
        set_cfg(1, 0, 1, 2'd0, 0, 0);
        wr_data = 32'h0000_00B7;
        clear_mon();
        pulse_start();
        repeat (3) @(negedge clk);
        cfg_len = 2'd3;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done("R11 retrigger");
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        chk(rise_cnt == 2, "R11 length kept on retrigger", 32'(rise_cnt), 32'd2);
        chk(extra == 0, "R11 no second transfer", 32'(extra), 32'd0);
    endtask

    task automatic t_rd_hold();
        t_read(2'd1, 32'h0000_4E2A);
        t_write(2'd3, 32'hCAFE_F00D);
        chk(rd_data === 32'h0000_4E2A, "R12 write leaves rd_data", rd_data, 32'h0000_4E2A);
    endtask

    bit finished = 0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(500_000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(2'd1, 32'h0000_A5C3);
        t_write(2'd3, 32'h1234_5678);
        t_write(2'd0, 32'h0000_009E);
        t_write(2'd2, 32'h0069_3F1D);
        t_read(2'd3, 32'hDEAD_BEEF);
        t_read(2'd0, 32'h0000_003C);
        t_read(2'd2, 32'h00A1_B2C3);
        t_reject(1, 1, 0, 0, "R6 quad+dual");
        t_reject(1, 0, 1, 0, "R7 three-wire");
        t_reject(1, 0, 0, 1, "R7 byte-swap");
        t_reject(0, 0, 0, 0, "R8 quad off");
        t_retrigger();
        t_rd_hold();
        finish_run();
    end
endmodule